// File: doc/BRIEF.md
# H-Bridge Gate-Drive Control Decoder

This block turns logic-level commands into the four gate-enable signals of a power stage made of two legs, A and B. Each leg has a high-side and a low-side switch. A mode input gives the four command inputs two meanings. In full-bridge mode they act as direction, PWM, quadrant-select and enable for one H-bridge, and a brake input can override them. In half-bridge mode the same inputs act as an input and an enable for each of two independent legs.

Protection inputs take priority over every command. These are an undervoltage flag and one overcurrent-blanking flag per leg, all synchronous to the clock. Each leg also has a dead-time sequencer. When a leg moves from one switch to the other, the sequencer holds both of that leg's switches off for a programmable number of cycles. All gate outputs come directly from flops, so they change one cycle after the inputs are sampled.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are 0, and they stay 0 until the first rising edge after `rst_n` is released.
- R2: When `bridge_mode`=0, each leg is handled on its own. Leg A is enabled by `en_or_ena`=1 and driven by `dir_or_ina`. Leg B is enabled by `pwm_or_enb`=1 and driven by `qsel_or_inb`. An enabled leg turns its high side on when its input is 1 and its low side on when its input is 0. A disabled leg has both gates off.
- R3: When `bridge_mode`=1, enabled, with `pwm_or_enb`=1: `dir_or_ina`=1 turns on the A high side and the B low side, and `dir_or_ina`=0 turns on the B high side and the A low side.
- R4: When `bridge_mode`=1, enabled, with `pwm_or_enb`=0: if `qsel_or_inb`=1, the high side of the selected diagonal stays on and its low side turns off. If `qsel_or_inb`=0, all four gates are off. An unused `qsel_or_inb` is expected to be tied high on the board.
- R5: When `bridge_mode`=1 and `brake`=1, both low sides are on and both high sides are off. When `bridge_mode`=0, `brake` has no effect.
- R6: When `bridge_mode`=1 and `en_or_ena`=0, all four gates are off. When `bridge_mode`=0, each enable affects only its own leg.
- R7: When `uv_fault`=1, all four gates are off in either mode.
- R8: In full-bridge mode, either `oc_blank_a` or `oc_blank_b` turns all four gates off. In half-bridge mode, each overcurrent flag turns off only its own leg.
- R9: Priority from highest to lowest is: undervoltage, overcurrent blanking, disable, brake, then PWM decoding.
- R10: When a leg switches from high side to low side, or from low side to high side, both of its gates are off for exactly `DEAD_CYCLES` cycles first. Turning a leg off takes effect at once. A leg that returns to the side it last drove turns on at once.
- R11: Gate outputs are registered. A change in the commands appears at the outputs after the next rising edge, subject to R10.
- R12: The high-side and low-side gates of one leg are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_mode | input | 1 | 1 = full bridge, 0 = two half-bridges |
| dir_or_ina | input | 1 | Direction (full) / leg A input (half) |
| pwm_or_enb | input | 1 | PWM (full) / leg B enable (half) |
| qsel_or_inb | input | 1 | Quadrant select (full) / leg B input (half) |
| en_or_ena | input | 1 | Bridge enable (full) / leg A enable (half) |
| brake | input | 1 | Brake request, full-bridge mode only |
| uv_fault | input | 1 | Undervoltage condition |
| oc_blank_a | input | 1 | Overcurrent blanking active on leg A |
| oc_blank_b | input | 1 | Overcurrent blanking active on leg B |
| gate_hi_a | output | 1 | Leg A high-side gate enable |
| gate_lo_a | output | 1 | Leg A low-side gate enable |
| gate_hi_b | output | 1 | Leg B high-side gate enable |
| gate_lo_b | output | 1 | Leg B low-side gate enable |

## Verification
In full-bridge mode the direction is flipped with PWM high. This tells the two diagonals apart, and each flip exercises the dead-time gap in both legs. PWM is then toggled with quadrant select at 1 and at 0. This separates low-side-only chopping from chopping both switches, and shows whether the high side is allowed to return at once. Brake, disable, undervoltage and each overcurrent flag are applied on top of one another in both modes, which exposes any wrong priority order and any protection that reaches the wrong leg. A long run of random input changes with random hold lengths then compares every cycle against the behavioural model. This covers transitions that arrive while a dead-time gap is still running.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Leg command: bit 0 drives the high side, bit 1 the low side.
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_cmd_e;

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_A    = 0;
  localparam int unsigned LEG_B    = 1;

endpackage

// File: rtl/hbg_cmd_decode.sv
module hbg_cmd_decode
  import hbg_pkg::*;
(
  input  logic     bridge_mode,
  input  logic     dir_or_ina,
  input  logic     pwm_or_enb,
  input  logic     qsel_or_inb,
  input  logic     en_or_ena,
  input  logic     brake,
  input  logic     uv_fault,
  input  logic     oc_blank_a,
  input  logic     oc_blank_b,
  output leg_cmd_e req_a,
  output leg_cmd_e req_b
);

  leg_cmd_e drv_side;   // command for the leg holding the diagonal's high switch
  leg_cmd_e sink_side;  // command for the leg holding the diagonal's low switch
  logic     any_oc;

  assign any_oc = oc_blank_a | oc_blank_b;

  // Full-bridge diagonal commands (R3, R4)
  always_comb begin
    drv_side  = (pwm_or_enb || qsel_or_inb) ? LEG_HI : LEG_OFF;
    sink_side = pwm_or_enb ? LEG_LO : LEG_OFF;
  end

  // Priority chain (R9): undervoltage, overcurrent, disable, brake, PWM
  always_comb begin
    req_a = LEG_OFF;
    req_b = LEG_OFF;
    if (uv_fault) begin
      req_a = LEG_OFF;
      req_b = LEG_OFF;
    end else if (bridge_mode) begin
      if (any_oc || !en_or_ena) begin
        req_a = LEG_OFF;
        req_b = LEG_OFF;
      end else if (brake) begin
        req_a = LEG_LO;
        req_b = LEG_LO;
      end else if (dir_or_ina) begin
        req_a = drv_side;
        req_b = sink_side;
      end else begin
        req_a = sink_side;
        req_b = drv_side;
      end
    end else begin
      if (!oc_blank_a && en_or_ena) begin
        req_a = dir_or_ina ? LEG_HI : LEG_LO;
      end
      if (!oc_blank_b && pwm_or_enb) begin
        req_b = qsel_or_inb ? LEG_HI : LEG_LO;
      end
    end
  end

endmodule

// File: rtl/hbg_leg_sequencer.sv
module hbg_leg_sequencer
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_e req_i,
  output logic     hi_o,
  output logic     lo_o
);

  localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEAD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  leg_cmd_e         state_q, state_d;
  leg_cmd_e         last_q, last_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             gap_en;
  logic             gap_done;

  assign gap_done = (gap_q >= CNT_MAX);

  // Next-state logic (R10)
  always_comb begin
    state_d = state_q;
    last_d  = last_q;
    gap_d   = gap_q;
    gap_en  = 1'b0;
    if (state_q == LEG_OFF) begin
      if ((req_i != LEG_OFF) && ((req_i == last_q) || gap_done)) begin
        state_d = req_i;
      end else if (!gap_done) begin
        gap_en = 1'b1;
        gap_d  = gap_q + CNT_ONE;
      end
    end else if (req_i != state_q) begin
      state_d = LEG_OFF;
      last_d  = state_q;
      gap_en  = 1'b1;
      gap_d   = CNT_ONE;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LEG_OFF;
      last_q  <= LEG_OFF;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= CNT_MAX;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  // Gate bits come straight from the state flops (R11)
  assign hi_o = state_q[0];
  assign lo_o = state_q[1];

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_mode,
  input  logic dir_or_ina,
  input  logic pwm_or_enb,
  input  logic qsel_or_inb,
  input  logic en_or_ena,
  input  logic brake,
  input  logic uv_fault,
  input  logic oc_blank_a,
  input  logic oc_blank_b,
  output logic gate_hi_a,
  output logic gate_lo_a,
  output logic gate_hi_b,
  output logic gate_lo_b
);

  leg_cmd_e req_a, req_b;
  leg_cmd_e leg_req [NUM_LEGS];
  logic     leg_hi  [NUM_LEGS];
  logic     leg_lo  [NUM_LEGS];

  hbg_cmd_decode u_decode (
    .bridge_mode (bridge_mode),
    .dir_or_ina  (dir_or_ina),
    .pwm_or_enb  (pwm_or_enb),
    .qsel_or_inb (qsel_or_inb),
    .en_or_ena   (en_or_ena),
    .brake       (brake),
    .uv_fault    (uv_fault),
    .oc_blank_a  (oc_blank_a),
    .oc_blank_b  (oc_blank_b),
    .req_a       (req_a),
    .req_b       (req_b)
  );

  assign leg_req[LEG_A] = req_a;
  assign leg_req[LEG_B] = req_b;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg_sequencer #(
      .DEAD_CYCLES (DEAD_CYCLES)
    ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (leg_req[g]),
      .hi_o  (leg_hi[g]),
      .lo_o  (leg_lo[g])
    );
  end

  assign gate_hi_a = leg_hi[LEG_A];
  assign gate_lo_a = leg_lo[LEG_A];
  assign gate_hi_b = leg_hi[LEG_B];
  assign gate_lo_b = leg_lo[LEG_B];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int unsigned DEAD_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bridge_mode,
  input logic en_or_ena,
  input logic brake,
  input logic uv_fault,
  input logic oc_blank_a,
  input logic oc_blank_b,
  input logic gate_hi_a,
  input logic gate_lo_a,
  input logic gate_hi_b,
  input logic gate_lo_b
);

  localparam int unsigned CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEAD_CYCLES);

  logic hi [2];
  logic lo [2];
  logic all_off;

  assign hi[0]   = gate_hi_a;
  assign lo[0]   = gate_lo_a;
  assign hi[1]   = gate_hi_b;
  assign lo[1]   = gate_lo_b;
  assign all_off = !gate_hi_a && !gate_lo_a && !gate_hi_b && !gate_lo_b;

  // R1: outputs held off during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_off: assert (all_off);
    end
  end

  // R7
  a_r7_uv_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |=> all_off);

  // R8: full-bridge overcurrent
  a_r8_oc_full_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_mode && (oc_blank_a || oc_blank_b)) |=> all_off);

  // R8: half-bridge overcurrent is local
  a_r8_oc_half_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_mode && oc_blank_a) |=> (!gate_hi_a && !gate_lo_a));
  a_r8_oc_half_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_mode && oc_blank_b) |=> (!gate_hi_b && !gate_lo_b));

  // R6
  a_r6_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_mode && !en_or_ena) |=> all_off);

  // R5
  a_r5_brake_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_mode && brake) |=> (!gate_hi_a && !gate_hi_b));

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [1:0]    last_q;   // 1 = high side was last on, 2 = low side
    logic [CW-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q <= 2'd0;
        off_q  <= CMAX;
      end else if (hi[g] || lo[g]) begin
        last_q <= hi[g] ? 2'd1 : 2'd2;
        off_q  <= '0;
      end else if (off_q < CMAX) begin
        off_q  <= off_q + CW'(1);
      end
    end

    // R12
    a_r12_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi[g] && lo[g]));

    // R10: swapping side only after the full gap
    a_r10_gap_to_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lo[g]) && (last_q == 2'd1)) |-> (off_q >= CMAX));
    a_r10_gap_to_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi[g]) && (last_q == 2'd2)) |-> (off_q >= CMAX));
  end

endmodule

bind hbridge_gate_ctrl hbg_checker #(
  .DEAD_CYCLES (DEAD_CYCLES)
) u_hbg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bridge_mode (bridge_mode),
  .en_or_ena   (en_or_ena),
  .brake       (brake),
  .uv_fault    (uv_fault),
  .oc_blank_a  (oc_blank_a),
  .oc_blank_b  (oc_blank_b),
  .gate_hi_a   (gate_hi_a),
  .gate_lo_a   (gate_lo_a),
  .gate_hi_b   (gate_hi_b),
  .gate_lo_b   (gate_lo_b)
);

// File: tb/test_hbridge_gate_ctrl.sv
module test_hbridge_gate_ctrl;

  localparam int DT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b1, dir = 1'b0, pwm = 1'b0, qs = 1'b1, en = 1'b0;
  logic brk = 1'b0, uv = 1'b0, oca = 1'b0, ocb = 1'b0;
  logic hi_a, lo_a, hi_b, lo_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // Model state per leg: 0 off, 1 high, 2 low
  int m_st [2];
  int m_last [2];
  int m_cnt [2];

  always #5 clk = ~clk;

  hbridge_gate_ctrl #(.DEAD_CYCLES(DT)) i_hbridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .bridge_mode(mode), .dir_or_ina(dir),
    .pwm_or_enb(pwm), .qsel_or_inb(qs), .en_or_ena(en), .brake(brk),
    .uv_fault(uv), .oc_blank_a(oca), .oc_blank_b(ocb),
    .gate_hi_a(hi_a), .gate_lo_a(lo_a), .gate_hi_b(hi_b), .gate_lo_b(lo_b)
  );

  // Requested side for a leg, straight from the requirements
  function automatic int wanted(int leg);
    int hl;
    if (uv) return 0;                                   // R7
    if (mode) begin
      if (oca || ocb) return 0;                         // R8
      if (!en) return 0;                                // R6
      if (brk) return 2;                                // R5
      hl = dir ? 0 : 1;                                 // R3
      if (leg == hl) return (pwm || qs) ? 1 : 0;        // R4
      return pwm ? 2 : 0;
    end
    if (leg == 0) return (oca || !en) ? 0 : (dir ? 1 : 2);   // R2
    return (ocb || !pwm) ? 0 : (qs ? 1 : 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        m_st[l] = 0; m_last[l] = 0; m_cnt[l] = DT;
      end
    end else begin
      for (int l = 0; l < 2; l++) begin
        int w;
        w = wanted(l);
        if (m_st[l] == 0) begin
          if (w != 0 && (w == m_last[l] || m_cnt[l] >= DT)) m_st[l] = w;
          else if (m_cnt[l] < DT) m_cnt[l]++;
        end else if (w != m_st[l]) begin
          m_last[l] = m_st[l]; m_st[l] = 0; m_cnt[l] = 1;   // R10
        end
      end
    end
  end

  // Compare every cycle, 2 ns after the edge
  always @(posedge clk) begin
    logic [3:0] exp_v, act_v;
    #2;
    exp_v = {m_st[0] == 1, m_st[0] == 2, m_st[1] == 1, m_st[1] == 2};
    act_v = {hi_a, lo_a, hi_b, lo_b};
    if (!done) begin
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s: gates {hiA,loA,hiB,loB} actual %b expected %b at %0t",
                 cur_req, act_v, exp_v, $time);
      end
    end
  end

  task automatic drive(input logic m, d, p, q, e, b, u, oa, ob);
    @(negedge clk);
    mode = m; dir = d; pwm = p; qs = q; en = e; brk = b; uv = u; oca = oa; ocb = ob;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    hold(3);
    @(negedge clk); rst_n = 1'b1;
    hold(2);
    // R3 / R11 / R10: diagonal selection and direction flips
    cur_req = "R3";
    drive(1, 1, 1, 1, 1, 0, 0, 0, 0); hold(8);
    cur_req = "R10";
    drive(1, 0, 1, 1, 1, 0, 0, 0, 0); hold(8);
    drive(1, 1, 1, 1, 1, 0, 0, 0, 0); hold(3);
    drive(1, 0, 1, 1, 1, 0, 0, 0, 0); hold(8);
    // R4: PWM chopping with both quadrant-select settings
    cur_req = "R4";
    for (int i = 0; i < 6; i++) begin
      drive(1, 1, i[0], 1, 1, 0, 0, 0, 0); hold(3);
    end
    for (int i = 0; i < 6; i++) begin
      drive(1, 1, i[0], 0, 1, 0, 0, 0, 0); hold(7);
    end
    // R5: brake, then brake ignored in half mode
    cur_req = "R5";
    drive(1, 1, 1, 1, 1, 1, 0, 0, 0); hold(8);
    drive(0, 1, 1, 1, 1, 1, 0, 0, 0); hold(8);
    // R6: disable
    cur_req = "R6";
    drive(1, 1, 1, 1, 0, 0, 0, 0, 0); hold(4);
    drive(1, 1, 1, 1, 0, 1, 0, 0, 0); hold(4);
    drive(0, 1, 0, 0, 1, 0, 0, 0, 0); hold(6);
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0); hold(6);
    // R2: half-bridge inputs in every combination
    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      drive(0, i[0], i[1], i[2], i[3], 0, 0, 0, 0); hold(6);
    end
    // R7: undervoltage over brake and normal operation
    cur_req = "R7";
    drive(1, 1, 1, 1, 1, 0, 1, 0, 0); hold(4);
    drive(1, 1, 1, 1, 1, 1, 1, 0, 0); hold(4);
    drive(0, 1, 1, 0, 1, 0, 1, 0, 0); hold(4);
    // R8: overcurrent in both modes
    cur_req = "R8";
    drive(1, 1, 1, 1, 1, 0, 0, 0, 1); hold(4);
    drive(1, 0, 1, 1, 1, 0, 0, 1, 0); hold(4);
    drive(0, 1, 1, 0, 1, 0, 0, 1, 0); hold(6);
    drive(0, 1, 1, 0, 1, 0, 0, 0, 1); hold(6);
    // R9: stacked conditions
    cur_req = "R9";
    drive(1, 1, 1, 1, 0, 1, 0, 1, 0); hold(4);
    drive(1, 1, 1, 1, 1, 1, 0, 1, 0); hold(4);
    drive(1, 1, 1, 1, 1, 1, 0, 0, 0); hold(6);
    // R12 / R11: random sequences with short holds
    cur_req = "R12";
    for (int i = 0; i < 1500; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      drive(r[0], r[1], r[2], r[3] | r[8], r[4] | r[7], r[5] & r[6], r[6] & r[7] & r[8],
            r[7] & r[5] & r[3], r[8] & r[4] & r[2]);
      hold($urandom_range(0, 6));
    end
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    hold(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule